// File: doc/BRIEF.md
# SPI Programmable Bit-Clock Generator

This block derives the serial bit clock of an SPI port from a fast reference clock, nominally 300 MHz. In master mode a 12-bit integer divisor sets the bit period in reference cycles. The block drives SCK, starting with the low phase as SPI mode 0 requires. It also issues a one-cycle sample strobe at each rising SCK edge and a one-cycle shift strobe at each falling edge. Software picks the divisor as the ceiling of reference frequency over the target rate, so the real rate never rises above the target. For example, a 22 gives about 13.64 Mbps against a 14 Mbps target.

In slave mode the divisor input is ignored and the divider runs at a fixed ratio of 6. Its ticks sample an external SCK after a two-flop synchroniser. A level change between two successive ticks produces a sample strobe (rising) or a shift strobe (falling). The bit rate is then set by the external master.

Top module: `spi_bitclk_gen`

## Requirements
- R1: In master mode with divisor N (N >= 2), SCK has period N reference cycles. Counting from the first enabled cycle, it is low for ceil(N/2) cycles and then high for floor(N/2) cycles.
- R2: A divisor of 0 or 1 behaves exactly as a divisor of 2.
- R3: In master mode, sample_stb is high for one cycle in the first cycle of each SCK high phase, and never at any other time.
- R4: In master mode, shift_stb is high for one cycle in the first cycle of each SCK low phase except the very first one after enable, and never at any other time.
- R5: While enable is low, sck_out, sample_stb and shift_stb are low. The divider restarts from its first low-phase cycle when enable rises.
- R6: In slave mode, sck_out stays low and the divider ticks every 6th reference cycle, on enabled cycles 5, 11, 17, and so on, whatever the divisor input holds.
- R7: In slave mode, each rising edge of sck_in held at least 12 reference cycles produces exactly one sample_stb pulse. Each such falling edge produces exactly one shift_stb pulse. Pulses occur only on tick cycles.
- R8: The divisor is 12 bits wide, and large values such as 600 give exact periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the divider; low holds it idle |
| slave_mode | input | 1 | 1 = recover external SCK, 0 = generate SCK |
| divisor | input | 12 | Master-mode bit period in reference cycles |
| sck_in | input | 1 | External SCK (slave mode) |
| sck_out | output | 1 | Generated SCK (master mode) |
| sample_stb | output | 1 | One-cycle strobe at rising SCK edge |
| shift_stb | output | 1 | One-cycle strobe at falling SCK edge |

## Verification
The assertions check on every cycle the things that hold whatever the divisor or input pattern. These are: the idle state of the counter, the bound on the slave-mode counter, that the two strobes never coincide, and that a master sample strobe always coincides with an SCK rise. Exact period and duty cycle, divisor clamping, skipping the shift strobe at start-up, and the one-strobe-per-edge count in slave mode need long scenarios. The bench covers these by sweeping divisors 0 to 20 plus 600 and by driving external clock patterns.

// File: rtl/spi_bitclk_gen.sv
module spi_bitclk_gen #(
  parameter int DIV_W     = 12,
  parameter int SLV_RATIO = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             slave_mode,
  input  logic [DIV_W-1:0] divisor,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sample_stb,
  output logic             shift_stb
);
  logic [DIV_W-1:0] cnt, eff_n, lim, lo_len;
  logic started, sync1, sync2, seen, tick, master;

  assign master = enable && !slave_mode;
  assign eff_n  = (divisor < DIV_W'(2)) ? DIV_W'(2) : divisor;
  assign lim    = slave_mode ? DIV_W'(SLV_RATIO) : eff_n;
  assign lo_len = eff_n - (eff_n >> 1);
  assign tick   = enable && slave_mode && (cnt == DIV_W'(SLV_RATIO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      started <= 1'b0;
    end else if (!enable) begin
      cnt     <= '0;
      started <= 1'b0;
    end else if (cnt >= lim - DIV_W'(1)) begin
      cnt     <= '0;
      started <= 1'b1;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      seen  <= 1'b0;
    end else begin
      sync1 <= sck_in;
      sync2 <= sync1;
      if (!enable || !slave_mode || tick) seen <= sync2;
    end
  end

  assign sck_out    = master && (cnt >= lo_len);
  assign sample_stb = master ? (cnt == lo_len) : (tick && sync2 && !seen);
  assign shift_stb  = master ? (cnt == '0 && started) : (tick && !sync2 && seen);

  a_r5_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt == '0));
  a_r6_slave_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && slave_mode) |=> (cnt < DIV_W'(SLV_RATIO)));
  a_r3_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && shift_stb));
  a_r3_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (master && sample_stb && $past(master) && $stable(divisor)) |-> $rose(sck_out));
endmodule

// File: tb/test_spi_bitclk_gen.sv
module test_spi_bitclk_gen;
  logic clk = 0, rst_n = 0, enable = 0, slave_mode = 0, sck_in = 0;
  logic [11:0] divisor = 0;
  logic sck_out, sample_stb, shift_stb;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_bitclk_gen i_spi_bitclk_gen (.clk(clk), .rst_n(rst_n), .enable(enable),
    .slave_mode(slave_mode), .divisor(divisor), .sck_in(sck_in),
    .sck_out(sck_out), .sample_stb(sample_stb), .shift_stb(shift_stb));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_master(input int dv, input int ncyc);
    int n, lo, bad_sck, bad_smp, bad_sh;
    n = (dv < 2) ? 2 : dv;
    lo = n - n / 2;
    bad_sck = 0; bad_smp = 0; bad_sh = 0;
    @(negedge clk);
    enable = 0; slave_mode = 0; divisor = 12'(dv);
    @(negedge clk);
    chk("R5 idle sck", int'(sck_out), 0);
    chk("R5 idle strobes", int'(sample_stb | shift_stb), 0);
    enable = 1;
    for (int k = 0; k < ncyc; k++) begin
      #2;
      if (int'(sck_out) != int'((k % n) >= lo)) bad_sck++;
      if (int'(sample_stb) != int'((k % n) == lo)) bad_smp++;
      if (int'(shift_stb) != int'((k % n) == 0 && k > 0)) bad_sh++;
      @(negedge clk);
    end
    enable = 0;
    chk((dv < 2) ? "R2 clamp sck" : (dv > 100 ? "R8 wide sck" : "R1 sck waveform"), bad_sck, 0);
    chk("R3 sample strobe", bad_smp, 0);
    chk("R4 shift strobe", bad_sh, 0);
  endtask

  initial begin
    int rises, falls, offtick, hi_seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk("R5 reset sck", int'(sck_out), 0);
    chk("R5 reset strobes", int'(sample_stb | shift_stb), 0);
    for (int d = 0; d <= 20; d++) run_master(d, 3 * ((d < 2) ? 2 : d) + 1);
    run_master(600, 1201);
    run_master(4095, 4096);

    @(negedge clk);
    slave_mode = 1; divisor = 12'd22; sck_in = 0;
    repeat (4) @(negedge clk);
    enable = 1;
    rises = 0; falls = 0; offtick = 0; hi_seen = 0;
    for (int k = 0; k < 1200; k++) begin
      sck_in = ((k / (12 + (k / 240))) % 2) == 1;
      #2;
      if (sck_out) hi_seen++;
      if (sample_stb) rises++;
      if (shift_stb) falls++;
      if ((sample_stb || shift_stb) && (k % 6) != 5) offtick++;
      @(negedge clk);
    end
    sck_in = 0;
    repeat (30) begin
      #2;
      if (shift_stb) falls++;
      if (sample_stb) rises++;
      @(negedge clk);
    end
    begin
      int exp_r, lvl, prev;
      exp_r = 0; prev = 0;
      for (int k = 0; k < 1200; k++) begin
        lvl = ((k / (12 + (k / 240))) % 2);
        if (lvl == 1 && prev == 0) exp_r++;
        prev = lvl;
      end
      chk("R7 slave rise count", rises, exp_r);
      chk("R7 slave fall count", falls, exp_r);
    end
    chk("R6 slave sck low", hi_seen, 0);
    chk("R6 R7 strobe only on tick", offtick, 0);
    enable = 0;
    @(negedge clk); #2;
    chk("R5 disabled strobes", int'(sample_stb | shift_stb | sck_out), 0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin repeat (150000) @(posedge clk); errors++; $display("FAIL watchdog actual 0 expected 1"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule